// File: doc/BRIEF.md
# Block-Erase Window Timer and Status Reporter

This block runs the phase of a flash block erase that follows acceptance of the erase command. The first erase confirm opens a collection window. Every further confirm names another block and restarts the window. Once the window expires with no new confirm, a modelled erase of fixed length runs. A confirm that names a block in a bank other than the one being collected aborts the whole operation. While the erase runs it can be suspended and later resumed. A failure can be injected to test the error reporting.

Reads are given as a strobe with a block index and a bank. Each read either returns a status byte or leaves the bus to array data, and `stat_sel_o` says which. The status byte carries these bits: bit 7 for completion polling, bit 6 as the operation toggle, bit 5 as the error flag, bit 3 as the window/erase phase, and bit 2 as the per-block toggle. Every time is a microsecond parameter multiplied by the clock frequency in MHz. A bench can therefore shrink every period to a few cycles.

Top module: `erase_window_ctrl`

## Requirements
- R1: In the idle state, a confirm records its block and bank and opens the window. A status read in that bank then returns `stat_sel_o`=1 with bit 3=0 and bit 7=0.
- R2: During the window, a confirm in the same bank adds its block and restarts a window of WINDOW_US*CLK_MHZ cycles. When the window expires the erase begins, and bit 3 reads 1 from then on.
- R3: During the window, a confirm whose bank differs from the collected bank aborts to idle. `busy_o` drops to 0 and reads return array data (`stat_sel_o`=0).
- R4: Bit 7 reads 0 while the erase runs. It reads 1 once ERASE_US*CLK_MHZ cycles of erase have elapsed.
- R5: Bit 6 inverts on each in-bank status read during the window and the erase. After completion it stays constant.
- R6: A `fail_inj_i` pulse during the erase makes bit 5 read 1 after completion. The completed state, bit 5 included, holds until `rd_rst_i`, and a confirm in that state is ignored. The next erase starts with bit 5 at 0.
- R7: `rd_rst_i` during the window cancels the operation to idle. During the erase it is ignored.
- R8: `susp_i` during the erase enters the suspended state after SUSP_US*CLK_MHZ cycles, and erase progress is frozen while suspended. `susp_i` during the window is ignored.
- R9: While suspended, a read of a collected block returns bit 6=1, bit 7=0 and an inverting bit 2. A read of an uncollected block returns array data.
- R10: `resume_i` with `resume_bank_i` equal to the collected bank continues the erase for its remaining cycles. A resume naming another bank is ignored.
- R11: Bit 2 inverts only on status reads of collected blocks. Reads of uncollected blocks in the same bank leave it unchanged.
- R12: After reset, and for any read naming a bank other than the collected one, `stat_sel_o` is 0 and the status byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfm_i | input | 1 | Erase confirm strobe |
| cfm_blk_i | input | BLK_AW | Block index of the confirm |
| cfm_bank_i | input | BANK_W | Bank of the confirmed block |
| susp_i | input | 1 | Erase suspend strobe |
| resume_i | input | 1 | Erase resume strobe |
| resume_bank_i | input | BANK_W | Bank addressed by the resume |
| rd_rst_i | input | 1 | Read-array/reset strobe |
| fail_inj_i | input | 1 | Erase failure injection |
| rd_i | input | 1 | Read strobe |
| rd_blk_i | input | BLK_AW | Block index of the read |
| rd_bank_i | input | BANK_W | Bank of the read |
| status_o | output | 8 | Status byte of the last read |
| stat_sel_o | output | 1 | 1: last read returns status, 0: array data |
| busy_o | output | 1 | An erase operation is open |

## Verification
The hardest situation to reach is the suspended state with part of the erase already done. The bench must get there by reaching the erase through an expired window, suspending mid-erase, and waiting out the suspend latency. Only then can it show three things. First, time spent suspended does not advance completion. Second, a resume to the wrong bank leaves the block suspended. Third, a correct resume finishes the remainder. From outside, suspension is told apart from a running erase only through one difference: a read of an uncollected block in the erasing bank falls back to array data. The bench uses that read as its probe. Bit 2 behaviour is compared between collected and uncollected reads relative to the first observed value, because the toggle state persists across operations.

// File: rtl/erase_pkg.sv
`timescale 1ns/1ps
package erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_ERASE,
    ST_SPEND,
    ST_SUSP,
    ST_DONE
  } ers_state_e;

  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TGL  = 6;
  localparam int unsigned BIT_ERR  = 5;
  localparam int unsigned BIT_PHS  = 3;
  localparam int unsigned BIT_BTGL = 2;
endpackage

// File: rtl/cyc_timer.sv
`timescale 1ns/1ps
module cyc_timer #(
  parameter int unsigned MAX_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int unsigned W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [W-1:0] LOAD_V = W'(MAX_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_V;
    else if (en_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/blk_collect.sv
`timescale 1ns/1ps
module blk_collect #(
  parameter int unsigned NUM_BLK = 16,
  parameter int unsigned BANK_W  = 1,
  localparam int unsigned BLK_AW = $clog2(NUM_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              first_i,
  input  logic              add_i,
  input  logic [BLK_AW-1:0] add_blk_i,
  input  logic [BANK_W-1:0] add_bank_i,
  input  logic [BLK_AW-1:0] rd_blk_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              cfm_same_o,
  output logic              rd_in_bank_o,
  output logic              rd_hit_o
);
  logic [NUM_BLK-1:0] mask;
  logic [BANK_W-1:0]  bank_q;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_mask
    logic sel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   sel_q <= 1'b0;
      else if (clear_i)                              sel_q <= 1'b0;
      else if (add_i && add_blk_i == BLK_AW'(b))     sel_q <= 1'b1;
    end
    assign mask[b] = sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bank_q <= '0;
    else if (first_i) bank_q <= add_bank_i;
  end

  assign bank_o       = bank_q;
  assign cfm_same_o   = (add_bank_i == bank_q);
  assign rd_in_bank_o = (rd_bank_i == bank_q);
  assign rd_hit_o     = mask[rd_blk_i];
endmodule

// File: rtl/status_gen.sv
`timescale 1ns/1ps
module status_gen
  import erase_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  ers_state_e st_i,
  input  logic       in_bank_i,
  input  logic       hit_i,
  input  logic       fail_i,
  output logic [7:0] status_o,
  output logic       sel_o
);
  logic [7:0] stat_q, stat_d;
  logic       sel_q, sel_d;
  logic       t6_q, t2_q, t6_flip, t2_flip;

  always_comb begin
    stat_d  = '0;
    sel_d   = 1'b0;
    t6_flip = 1'b0;
    t2_flip = 1'b0;
    unique case (st_i)
      ST_WIN, ST_ERASE, ST_SPEND: if (in_bank_i) begin
        sel_d            = 1'b1;
        stat_d[BIT_TGL]  = t6_q;
        stat_d[BIT_PHS]  = (st_i != ST_WIN);
        stat_d[BIT_BTGL] = t2_q;
        t6_flip          = 1'b1;
        t2_flip          = hit_i;
      end
      ST_SUSP: if (in_bank_i && hit_i) begin
        sel_d            = 1'b1;
        stat_d[BIT_TGL]  = 1'b1;
        stat_d[BIT_PHS]  = 1'b1;
        stat_d[BIT_BTGL] = t2_q;
        t2_flip          = 1'b1;
      end
      ST_DONE: if (in_bank_i) begin
        sel_d            = 1'b1;
        stat_d[BIT_POLL] = 1'b1;
        stat_d[BIT_TGL]  = t6_q;
        stat_d[BIT_ERR]  = fail_i;
        stat_d[BIT_PHS]  = 1'b1;
        stat_d[BIT_BTGL] = t2_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      sel_q  <= 1'b0;
      t6_q   <= 1'b0;
      t2_q   <= 1'b0;
    end else if (rd_i) begin
      stat_q <= stat_d;
      sel_q  <= sel_d;
      if (t6_flip) t6_q <= ~t6_q;
      if (t2_flip) t2_q <= ~t2_q;
    end
  end

  assign status_o = stat_q;
  assign sel_o    = sel_q;

  assert_window_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_bank_i && st_i == ST_WIN) |=> (sel_o && !status_o[BIT_PHS] && !status_o[BIT_POLL]));

  assert_other_bank_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_bank_i) |=> (!sel_o && status_o == 8'h00));
endmodule

// File: rtl/erase_window_ctrl.sv
`timescale 1ns/1ps
module erase_window_ctrl
  import erase_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned WINDOW_US = 100,
  parameter int unsigned SUSP_US   = 15,
  parameter int unsigned ERASE_US  = 500,
  parameter int unsigned NUM_BLK   = 16,
  parameter int unsigned BANK_W    = 1,
  localparam int unsigned BLK_AW   = $clog2(NUM_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfm_i,
  input  logic [BLK_AW-1:0] cfm_blk_i,
  input  logic [BANK_W-1:0] cfm_bank_i,
  input  logic              susp_i,
  input  logic              resume_i,
  input  logic [BANK_W-1:0] resume_bank_i,
  input  logic              rd_rst_i,
  input  logic              fail_inj_i,
  input  logic              rd_i,
  input  logic [BLK_AW-1:0] rd_blk_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic [7:0]        status_o,
  output logic              stat_sel_o,
  output logic              busy_o
);
  localparam int unsigned WIN_CYC = CLK_MHZ * WINDOW_US;
  localparam int unsigned SUS_CYC = CLK_MHZ * SUSP_US;
  localparam int unsigned ERS_CYC = CLK_MHZ * ERASE_US;

  ers_state_e st_q, st_d;
  logic win_load, ers_load, sus_load;
  logic win_exp, ers_exp, sus_exp;
  logic first, add, clear;
  logic cfm_same, rd_in_bank, rd_hit;
  logic [BANK_W-1:0] bank;
  logic fail_q;

  always_comb begin
    st_d     = st_q;
    win_load = 1'b0;
    ers_load = 1'b0;
    sus_load = 1'b0;
    first    = 1'b0;
    add      = 1'b0;
    clear    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cfm_i) begin
        st_d = ST_WIN; first = 1'b1; add = 1'b1; win_load = 1'b1;
      end
      ST_WIN: begin
        if (rd_rst_i) begin
          st_d = ST_IDLE; clear = 1'b1;
        end else if (cfm_i) begin
          if (cfm_same) begin
            add = 1'b1; win_load = 1'b1;
          end else begin
            st_d = ST_IDLE; clear = 1'b1;
          end
        end else if (win_exp) begin
          st_d = ST_ERASE; ers_load = 1'b1;
        end
      end
      ST_ERASE: begin
        if (ers_exp)     st_d = ST_DONE;
        else if (susp_i) begin
          st_d = ST_SPEND; sus_load = 1'b1;
        end
      end
      ST_SPEND: begin
        if (ers_exp)      st_d = ST_DONE;
        else if (sus_exp) st_d = ST_SUSP;
      end
      ST_SUSP: if (resume_i && resume_bank_i == bank) st_d = ST_ERASE;
      ST_DONE: if (rd_rst_i) begin
        st_d = ST_IDLE; clear = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                   fail_q <= 1'b0;
    else if (first)                                                fail_q <= 1'b0;
    else if (fail_inj_i && (st_q == ST_ERASE || st_q == ST_SPEND)) fail_q <= 1'b1;
  end

  cyc_timer #(.MAX_CYC(WIN_CYC)) i_win_timer (
    .clk_i, .rst_ni, .load_i(win_load), .en_i(st_q == ST_WIN), .expired_o(win_exp)
  );

  cyc_timer #(.MAX_CYC(ERS_CYC)) i_ers_timer (
    .clk_i, .rst_ni, .load_i(ers_load),
    .en_i(st_q == ST_ERASE || st_q == ST_SPEND), .expired_o(ers_exp)
  );

  cyc_timer #(.MAX_CYC(SUS_CYC)) i_sus_timer (
    .clk_i, .rst_ni, .load_i(sus_load), .en_i(st_q == ST_SPEND), .expired_o(sus_exp)
  );

  blk_collect #(.NUM_BLK(NUM_BLK), .BANK_W(BANK_W)) i_collect (
    .clk_i, .rst_ni,
    .clear_i(clear), .first_i(first), .add_i(add),
    .add_blk_i(cfm_blk_i), .add_bank_i(cfm_bank_i),
    .rd_blk_i, .rd_bank_i,
    .bank_o(bank), .cfm_same_o(cfm_same),
    .rd_in_bank_o(rd_in_bank), .rd_hit_o(rd_hit)
  );

  status_gen i_status (
    .clk_i, .rst_ni, .rd_i, .st_i(st_q),
    .in_bank_i(rd_in_bank), .hit_i(rd_hit), .fail_i(fail_q),
    .status_o, .sel_o(stat_sel_o)
  );

  assign busy_o = (st_q != ST_IDLE);

  assert_win_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WIN && !rd_rst_i && cfm_i && cfm_same) |=> (st_q == ST_WIN));

  assert_bank_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WIN && !rd_rst_i && cfm_i && !cfm_same) |=> (st_q == ST_IDLE));

  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && !rd_rst_i) |=> (st_q == ST_DONE));

  assert_rst_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERASE && rd_rst_i) |=> (st_q != ST_IDLE));

  assert_susp_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP) |-> !ers_exp);

  assert_resume_bank_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP && resume_i && resume_bank_i != bank) |=> (st_q == ST_SUSP));
endmodule

// File: tb/test_erase_window_ctrl.sv
`timescale 1ns/1ps
module test_erase_window_ctrl;
  localparam int NB = 16;
  localparam int AW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfm_i = 1'b0, susp_i = 1'b0, resume_i = 1'b0, rd_rst_i = 1'b0;
  logic fail_inj_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0] cfm_blk_i = '0, rd_blk_i = '0;
  logic [0:0] cfm_bank_i = '0, resume_bank_i = '0, rd_bank_i = '0;
  logic [7:0] status_o;
  logic stat_sel_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  erase_window_ctrl #(
    .CLK_MHZ(1), .WINDOW_US(20), .SUSP_US(4), .ERASE_US(60), .NUM_BLK(NB), .BANK_W(1)
  ) i_erase_window_ctrl (
    .clk_i, .rst_ni, .cfm_i, .cfm_blk_i, .cfm_bank_i, .susp_i, .resume_i, .resume_bank_i,
    .rd_rst_i, .fail_inj_i, .rd_i, .rd_blk_i, .rd_bank_i, .status_o, .stat_sel_o, .busy_o
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic confirm(int blk, int bank);
    cfm_i = 1'b1; cfm_blk_i = AW'(blk); cfm_bank_i = 1'(bank);
    @(negedge clk_i);
    cfm_i = 1'b0;
  endtask

  task automatic pulse_rst();
    rd_rst_i = 1'b1; @(negedge clk_i); rd_rst_i = 1'b0;
  endtask

  task automatic pulse_susp();
    susp_i = 1'b1; @(negedge clk_i); susp_i = 1'b0;
  endtask

  task automatic pulse_fail();
    fail_inj_i = 1'b1; @(negedge clk_i); fail_inj_i = 1'b0;
  endtask

  task automatic resume(int bank);
    resume_i = 1'b1; resume_bank_i = 1'(bank);
    @(negedge clk_i);
    resume_i = 1'b0;
  endtask

  task automatic rd(int blk, int bank, output logic [7:0] s, output logic sel);
    rd_i = 1'b1; rd_blk_i = AW'(blk); rd_bank_i = 1'(bank);
    @(negedge clk_i);
    rd_i = 1'b0;
    s = status_o; sel = stat_sel_o;
  endtask

  task automatic t_reset();
    logic [7:0] s; logic sel;
    chk("R12 busy after reset", busy_o, 0);
    rd(0, 0, s, sel);
    chk("R12 sel after reset", sel, 0);
    chk("R12 status after reset", s, 0);
  endtask

  task automatic t_window();
    logic [7:0] s, s2; logic sel;
    confirm(2, 0);
    rd(2, 0, s, sel);
    chk("R1 sel in window", sel, 1);
    chk("R1 bit3 in window", s[3], 0);
    chk("R1 bit7 in window", s[7], 0);
    tick(9);
    confirm(4, 0);
    tick(12);
    rd(2, 0, s, sel);
    chk("R2 window restarted bit3", s[3], 0);
    tick(20);
    rd(4, 0, s, sel);
    chk("R2 erase begun bit3", s[3], 1);
    chk("R4 bit7 while erasing", s[7], 0);
    rd(4, 0, s2, sel);
    chk("R5 bit6 inverts while erasing", s2[6], !s[6]);
    tick(80);
    rd(4, 0, s, sel);
    chk("R4 bit7 after completion", s[7], 1);
    rd(4, 0, s2, sel);
    chk("R5 bit6 steady after completion", s2[6], s[6]);
    pulse_rst();
    rd(4, 0, s, sel);
    chk("R6 sel after reset from done", sel, 0);
  endtask

  task automatic t_abort();
    logic [7:0] s; logic sel;
    confirm(1, 0);
    confirm(6, 1);
    rd(1, 0, s, sel);
    chk("R3 sel after abort", sel, 0);
    chk("R3 busy after abort", busy_o, 0);
  endtask

  task automatic t_rdrst();
    logic [7:0] s; logic sel;
    confirm(1, 0);
    tick(3);
    pulse_rst();
    rd(1, 0, s, sel);
    chk("R7 cancel in window", sel, 0);
    confirm(1, 0);
    tick(25);
    pulse_rst();
    rd(1, 0, s, sel);
    chk("R7 ignored in erase sel", sel, 1);
    chk("R7 ignored in erase bit3", s[3], 1);
    tick(80);
    rd(1, 0, s, sel);
    chk("R4 completion after ignored reset", s[7], 1);
    pulse_rst();
  endtask

  task automatic t_fail();
    logic [7:0] s; logic sel;
    confirm(0, 1);
    tick(25);
    pulse_fail();
    tick(80);
    rd(0, 1, s, sel);
    chk("R6 bit5 after failure", s[5], 1);
    chk("R6 bit7 after failure", s[7], 1);
    confirm(3, 1);
    rd(0, 1, s, sel);
    chk("R6 confirm ignored bit5", s[5], 1);
    chk("R6 confirm ignored busy", busy_o, 1);
    pulse_rst();
    rd(0, 1, s, sel);
    chk("R6 cleared by reset", sel, 0);
    confirm(0, 1);
    tick(105);
    rd(0, 1, s, sel);
    chk("R6 clean erase bit5", s[5], 0);
    chk("R6 clean erase bit7", s[7], 1);
    pulse_rst();
  endtask

  task automatic t_suspend();
    logic [7:0] a, b, s; logic sel;
    confirm(3, 0);
    pulse_susp();
    confirm(5, 0);
    tick(25);
    rd(7, 0, s, sel);
    chk("R8 suspend in window ignored", sel, 1);
    rd(3, 0, a, sel);
    rd(3, 0, b, sel);
    chk("R11 bit2 inverts on collected", b[2], !a[2]);
    rd(7, 0, s, sel);
    chk("R11 bit2 unchanged on uncollected", s[2], a[2]);
    rd(7, 0, s, sel);
    chk("R11 bit2 still unchanged", s[2], a[2]);
    pulse_susp();
    tick(8);
    rd(3, 0, a, sel);
    chk("R9 sel collected", sel, 1);
    chk("R9 bit6 suspended", a[6], 1);
    chk("R9 bit7 suspended", a[7], 0);
    rd(3, 0, b, sel);
    chk("R9 bit2 inverts suspended", b[2], !a[2]);
    rd(7, 0, s, sel);
    chk("R9 uncollected gives array", sel, 0);
    rd(5, 1, s, sel);
    chk("R12 other bank gives array", sel, 0);
    tick(150);
    rd(5, 0, s, sel);
    chk("R8 frozen bit7", s[7], 0);
    chk("R8 frozen bit6", s[6], 1);
    resume(1);
    tick(2);
    rd(7, 0, s, sel);
    chk("R10 wrong bank resume ignored", sel, 0);
    resume(0);
    rd(7, 0, s, sel);
    chk("R10 resumed sel", sel, 1);
    chk("R10 resumed bit7", s[7], 0);
    tick(80);
    rd(7, 0, s, sel);
    chk("R10 resumed erase completes", s[7], 1);
    pulse_rst();
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_window();
    t_abort();
    t_rdrst();
    t_fail();
    t_suspend();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule